// File: doc/BRIEF.md
# Chained Reed-Solomon Parity Generator

This block builds the two-level parity chain that is stored next to a program image, so that an instruction integrity checker can later detect altered or injected instructions. It takes a stream of 16-bit instruction words, one per clock, each marked with a valid flag and a last flag. For every position t of the stream it produces two 8-bit parities. The first-level parity p1(t) is the Reed-Solomon (10,8) parity of the pair made of instruction t and instruction t+1. The second-level parity p2(t) is the Reed-Solomon (6,4) parity of the pair made of p1(t) and p1(t-1). Each parity therefore depends on its neighbours. Changing one word without recomputing the whole chain breaks the check.

All arithmetic is done over GF(16). Each encoder is a fully unrolled remainder divider, so a complete parity pair is ready in the same cycle that its inputs are present. The position t+1 must be known before p1(t) can be formed. For this reason the output for a position is issued one clock after the next instruction is accepted. After the last instruction of a stream, a flush state closes the chain with a zero successor. A new stream always starts its chain from a zero predecessor parity.

The controller has three states. S_IDLE means no instruction is pending. S_HOLD means one instruction is held and waits for its successor. S_FLUSH means the held instruction was the last one, and its parity is issued this cycle with a zero successor. The transitions are as follows:
- T_OPEN (S_IDLE to S_HOLD) on a valid word that is not last.
- T_SINGLE (S_IDLE to S_FLUSH) on a valid word marked last.
- T_WAIT (S_HOLD to S_HOLD) with no valid input.
- T_CHAIN (S_HOLD to S_HOLD) on a valid word that is not last.
- T_CLOSE (S_HOLD to S_FLUSH) on a valid word marked last.
- T_DRAIN (S_FLUSH to S_IDLE) with no valid input.
- T_REOPEN (S_FLUSH to S_HOLD) on a valid word that is not last.
- T_RESINGLE (S_FLUSH to S_FLUSH) on a valid word marked last.

Top module: `rsc_chain_parity`

## Requirements
- R1: The field is GF(16) with primitive polynomial x^4+x+1 and alpha = 4'h2. The generator is g(x)=(x+alpha)(x+alpha^2)=x^2+6x+8. Each parity is the remainder of x^2*m(x) mod g(x). The parity's higher-order symbol is in bits [7:4] and its constant symbol in bits [3:0]. The message followed by its parity therefore evaluates to zero at alpha and at alpha^2.
- R2: The p1 message has eight symbols: instruction t is the higher-order half and instruction t+1 the lower half. Within a word, bits [15:12] carry the highest coefficient. For the words 16'h0000 followed by 16'h0001, p1 is 8'h68.
- R3: The p2 message has four symbols: p1(t) is the higher-order half and p1(t-1) the lower half. Bits [7:4] of each carry the higher coefficient.
- R4: The output for position t (out_valid high for exactly one cycle, with out_p1 and out_p2) appears in the cycle after the clock edge that accepts instruction t+1. Each accepted instruction gives exactly one output.
- R5: After an instruction marked last, its successor is taken as 16'h0000. Its output appears one cycle after the edge following the edge that accepted it.
- R6: p1(t-1) is taken as 8'h00 for the first position of every stream, both after reset and after a last word.
- R7: Reset (rst_n low) clears out_valid, out_p1 and out_p2 to zero. It discards any pending instruction, so that instruction never produces an output.
- R8: A new stream may start in the cycle right after a last word, or in any later cycle. No output of either stream is lost or altered by this.
- R9: in_last while in_valid is low has no effect: the pending chain continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_data | input | 16 | Instruction word |
| in_last | input | 1 | Word is the last of its stream (qualified by in_valid) |
| out_valid | output | 1 | Parity pair for one position is present |
| out_p1 | output | 8 | First-level parity p1(t) |
| out_p2 | output | 8 | Second-level parity p2(t) |

## Verification
The assertions assume that in_valid, in_last and in_data are driven to known levels in every cycle after reset. The assertions also assume that in_last matters only when qualified by in_valid, since there is no backpressure and every valid word is taken. The stimulus changes inputs only on falling edges. It holds in_data at zero when no word is offered, and it pulses in_last alone only in gap cycles where the design must ignore it. Expected parities are computed in the bench by solving the two root equations of the generator rather than by long division, and each output codeword is also checked for zero syndromes.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int SYM_W  = 4;
    localparam int PAR_SYMS = 2;
    localparam int PAR_W  = SYM_W * PAR_SYMS;
    localparam logic [SYM_W-1:0] FIELD_RED = 4'h3;
    localparam logic [SYM_W-1:0] GEN_C1 = 4'h6;
    localparam logic [SYM_W-1:0] GEN_C0 = 4'h8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HOLD  = 2'd1,
        S_FLUSH = 2'd2
    } chain_state_t;

    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                 input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? FIELD_RED : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/rsc_rem_encoder.sv
module rsc_rem_encoder
    import rsc_pkg::*;
#(
    parameter int K = 8
) (
    input  logic [K*SYM_W-1:0] msg,
    output logic [PAR_W-1:0]   par
);

    localparam int MSG_W = K * SYM_W;

    always_comb begin
        logic [SYM_W-1:0] hi;
        logic [SYM_W-1:0] lo;
        logic [SYM_W-1:0] fb;
        hi = '0;
        lo = '0;
        for (int i = 0; i < K; i++) begin
            fb = msg[MSG_W-1-i*SYM_W -: SYM_W] ^ hi;
            hi = lo ^ gf_mul(fb, GEN_C1);
            lo = gf_mul(fb, GEN_C0);
        end
        par = {hi, lo};
    end

endmodule

// File: rtl/rsc_chain_ctrl.sv
module rsc_chain_ctrl
    import rsc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_last,
    output chain_state_t state,
    output logic         fire,
    output logic         flushing
);

    chain_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (in_valid) state_nx = in_last ? S_FLUSH : S_HOLD;
            end
            S_HOLD: begin
                if (in_valid) state_nx = in_last ? S_FLUSH : S_HOLD;
            end
            S_FLUSH: begin
                if (in_valid) state_nx = in_last ? S_FLUSH : S_HOLD;
                else          state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        flushing = (state == S_FLUSH);
        fire     = flushing || (state == S_HOLD && in_valid);
    end

    // R9: a stray last flag without a word leaves a held chain waiting
    a_r9_stray_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !in_valid) |=> (state == S_HOLD));

    // R5: the flush state lasts one cycle unless a new last word arrives
    a_r5_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLUSH && !in_valid) |=> (state == S_IDLE));

endmodule

// File: rtl/rsc_chain_parity.sv
module rsc_chain_parity
    import rsc_pkg::*;
#(
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_data,
    input  logic               in_last,
    output logic               out_valid,
    output logic [PAR_W-1:0]   out_p1,
    output logic [PAR_W-1:0]   out_p2
);

    localparam int WORD_SYMS = INSTR_W / SYM_W;
    localparam int K1 = 2 * WORD_SYMS;
    localparam int K2 = 2 * PAR_SYMS;

    chain_state_t      state;
    logic              fire;
    logic              flushing;
    logic [INSTR_W-1:0] pend;
    logic [PAR_W-1:0]  prev_p1;
    logic [INSTR_W-1:0] succ;
    logic [PAR_W-1:0]  p1_now;
    logic [PAR_W-1:0]  p2_now;

    rsc_chain_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .state    (state),
        .fire     (fire),
        .flushing (flushing)
    );

    assign succ = flushing ? '0 : in_data;

    rsc_rem_encoder #(.K(K1)) u_enc_p1 (
        .msg ({pend, succ}),
        .par (p1_now)
    );

    rsc_rem_encoder #(.K(K2)) u_enc_p2 (
        .msg ({p1_now, prev_p1}),
        .par (p2_now)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            prev_p1 <= '0;
        end else begin
            if (in_valid) pend <= in_data;
            if (fire)     prev_p1 <= flushing ? '0 : p1_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_p1    <= '0;
            out_p2    <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_p1 <= p1_now;
                out_p2 <= p2_now;
            end
        end
    end

    // R4: a successor word accepted while holding yields an output next cycle
    a_r4_chain_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && in_valid) |=> out_valid);

    // R4: no output follows a cycle with nothing pending
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> !out_valid);

    // R5: the last word's output follows the flush cycle
    a_r5_flush_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLUSH) |=> out_valid);

endmodule

// File: tb/rsc_chain_parity_bench.sv
module rsc_chain_parity_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [7:0]  out_p1;
    logic [7:0]  out_p2;

    always #5 clk = ~clk;

    rsc_chain_parity u_rsc_chain_parity (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_p1(out_p1), .out_p2(out_p2)
    );

    int ntot = 0;
    int nfail = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // format: [23:20] idle gap before, [19] stray last in gap, [18] last, [15:0] word
    localparam int NV = 12;
    localparam logic [23:0] TBL [0:NV-1] = '{
        24'h0_0_1234, 24'h0_0_ABCD, 24'h2_8_0F0F, 24'h0_4_FFFF,
        24'h0_0_8001, 24'h3_0_0000, 24'h0_4_7E5A, 24'h1_4_C3C3,
        24'h0_0_5555, 24'h1_8_AAAA, 24'h0_0_0001, 24'h0_4_9000
    };

    logic [15:0] sd [0:31];
    int          sgap [0:31];
    bit          sstray [0:31];
    bit          slast [0:31];
    int          sacc [0:31];
    int          obs_n = 0;
    logic [7:0]  obs_p1 [0:63];
    logic [7:0]  obs_p2 [0:63];
    int          obs_cyc [0:63];

    always @(negedge clk) begin
        if (out_valid && obs_n < 64) begin
            obs_p1[obs_n]  = out_p1;
            obs_p2[obs_n]  = out_p2;
            obs_cyc[obs_n] = cyc;
            obs_n = obs_n + 1;
        end
    end

    function automatic logic [3:0] bmul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] acc = 4'h0;
        for (int i = 3; i >= 0; i--) begin
            acc = {acc[2:0], 1'b0} ^ (acc[3] ? 4'h3 : 4'h0);
            if (a[i]) acc = acc ^ b;
        end
        return acc;
    endfunction

    function automatic logic [3:0] binv(input logic [3:0] a);
        logic [3:0] r = 4'h0;
        for (int v = 1; v < 16; v++) if (bmul(a, 4'(v)) == 4'h1) r = 4'(v);
        return r;
    endfunction

    // evaluate x^2*m(x) at point a, message symbols highest first from the top
    function automatic logic [3:0] evalx2(input logic [31:0] msg, input int ns, input logic [3:0] a);
        logic [3:0] h = 4'h0;
        for (int i = ns - 1; i >= 0; i--) h = bmul(h, a) ^ msg[i*4 +: 4];
        return bmul(bmul(h, a), a);
    endfunction

    // remainder solved from r(alpha)=S1, r(alpha^2)=S2
    function automatic logic [7:0] refpar(input logic [31:0] msg, input int ns);
        logic [3:0] s1, s2, r1, r0;
        s1 = evalx2(msg, ns, 4'h2);
        s2 = evalx2(msg, ns, 4'h4);
        r1 = bmul(s1 ^ s2, binv(4'h6));
        r0 = s1 ^ bmul(r1, 4'h2);
        return {r1, r0};
    endfunction

    function automatic bit synzero(input logic [31:0] msg, input int ns, input logic [7:0] par);
        bit ok = 1'b1;
        for (int k = 0; k < 2; k++) begin
            logic [3:0] a = (k == 0) ? 4'h2 : 4'h4;
            logic [3:0] h = 4'h0;
            for (int i = ns - 1; i >= 0; i--) h = bmul(h, a) ^ msg[i*4 +: 4];
            h = bmul(h, a) ^ par[7:4];
            h = bmul(h, a) ^ par[3:0];
            if (h != 4'h0) ok = 1'b0;
        end
        return ok;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        ntot++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic play(input int n);
        obs_n = 0;
        for (int i = 0; i < n; i++) begin
            for (int g = 0; g < sgap[i]; g++) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 16'h0; in_last = sstray[i];
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = sd[i]; in_last = slast[i];
            sacc[i] = cyc + 1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_data = 16'h0; in_last = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input int n, input string tag);
        logic [7:0] e1 [0:31];
        logic [7:0] e2 [0:31];
        chk(obs_n == n, {tag, " R4"}, "output count", obs_n, n);
        for (int i = 0; i < n; i++) begin
            logic [15:0] nx = (slast[i] || i == n - 1) ? 16'h0 : sd[i+1];
            bit first = (i == 0) || slast[i-1];
            logic [7:0] pv = first ? 8'h00 : e1[i-1];
            int ec = slast[i] ? sacc[i] + 1 : sacc[i+1];
            e1[i] = refpar({sd[i], nx}, 8);
            e2[i] = refpar({16'h0, e1[i], pv}, 4);
            if (i < obs_n) begin
                chk(obs_p1[i] == e1[i], slast[i] ? {tag, " R2 R5"} : {tag, " R2"},
                    $sformatf("p1[%0d]", i), obs_p1[i], e1[i]);
                chk(obs_p2[i] == e2[i], first ? {tag, " R3 R6"} : {tag, " R3"},
                    $sformatf("p2[%0d]", i), obs_p2[i], e2[i]);
                chk(obs_cyc[i] == ec, slast[i] ? {tag, " R5"} : {tag, " R4"},
                    $sformatf("cycle[%0d]", i), obs_cyc[i], ec);
                chk(synzero({sd[i], nx}, 8, obs_p1[i]) && synzero({16'h0, obs_p1[i], pv}, 4, obs_p2[i]),
                    {tag, " R1"}, $sformatf("syndrome[%0d]", i), 1, 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        ntot++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        chk(out_p1 == 8'h00, "R7", "out_p1 in reset", out_p1, 0);
        chk(out_p2 == 8'h00, "R7", "out_p2 in reset", out_p2, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 directed: known value 8'h68, chain closed by flush
        sd[0] = 16'h0000; sgap[0] = 0; sstray[0] = 0; slast[0] = 0;
        sd[1] = 16'h0001; sgap[1] = 0; sstray[1] = 0; slast[1] = 1;
        play(2);
        chk(obs_p1[0] == 8'h68, "R2", "hand value p1", obs_p1[0], 8'h68);
        verify(2, "directed");

        // table walk: gaps, stray last (R9), back-to-back streams (R8)
        for (int i = 0; i < NV; i++) begin
            sd[i]     = TBL[i][15:0];
            sgap[i]   = int'(TBL[i][23:20]);
            sstray[i] = TBL[i][19];
            slast[i]  = TBL[i][18];
        end
        play(NV);
        verify(NV, "table R8 R9");

        // R7: reset discards a pending word, then chain restarts from zero
        sd[0] = 16'h1111; sgap[0] = 0; sstray[0] = 0; slast[0] = 0;
        play(1);
        chk(obs_n == 0, "R7", "no output while holding", obs_n, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(obs_n == 0, "R7", "pending word dropped", obs_n, 0);
        sd[0] = 16'h0000; sgap[0] = 0; sstray[0] = 0; slast[0] = 0;
        sd[1] = 16'h0001; sgap[1] = 0; sstray[1] = 0; slast[1] = 1;
        play(2);
        verify(2, "after reset R7");

        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

endmodule